// File: doc/BRIEF.md
# Prescaled Slow-Clock Tick Timer

This block keeps a slow time base for a larger chip. It receives a one-cycle strobe for each edge of a 32.768 kHz slow clock and divides those edges by a programmable 16-bit value. Each time the divider wraps, a 32-bit tick counter advances by one and a pending flag is raised. While the interrupt enable is set, that flag drives a level interrupt. Software acknowledges the interrupt by reading the status register.

A new divisor is taken only through a restart write, and only while the interrupt is disabled. A restart also clears the tick counter and the divider. Divisor 32768 gives one tick per second and divisor 32 gives 1024 ticks per second. The fastest usable setting is 3, which gives about 10922 ticks per second.

Everything runs in a single clock domain. The slow-clock edge arrives as an enable strobe. Register access uses separate write and read strobes with a 2-bit word address, and read data is combinational from the address.

Top module: `slow_tick_timer`

## Requirements
- R1: After reset the mode register (address 0) reads 0x00008000: divisor 32768 in bits [15:0] and interrupt enable (bit 17) clear. The status register (address 1) reads 0, the counter register (address 2) reads 0, and `irq` is low.
- R2: The counter at address 2 advances by exactly one on the slow edge that completes each run of N slow-edge strobes, where N is the effective divisor. Clock cycles without a strobe do not advance the divider.
- R3: A divisor field of 0 acts as 65536, and a divisor field of 1 or 2 acts as 3. Any other value acts as itself.
- R4: A write to address 0 with bit 18 set, made while the stored enable is 0, loads bits [15:0] as the divisor and clears both the counter and the divider. Bit 17 of the same write is stored as the new enable.
- R5: While the stored enable is 1, a write to address 0 with bit 18 set leaves the divisor, the counter and the divider unchanged. Its bit 17 is still stored.
- R6: Every counter increment sets the pending flag, which reads at bit 1 of address 1. The flag stays set until it is acknowledged. `irq` is high exactly while the flag and the enable are both 1.
- R7: A read of address 1 returns the pending flag in bit 1, and that read alone clears the flag on the following clock edge.
- R8: If a counter increment happens in the same cycle as a status read, the flag remains set after that cycle.
- R9: Reads of address 0 and address 2 leave the pending flag unchanged. Bit 18 of address 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_edge | input | 1 | One-cycle strobe per slow-clock edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 mode, 1 status, 2 counter |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt, pending flag gated by enable |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that the divisor changes only through an accepted restart, so the divider position is always below the effective divisor. The bench drives every access on its own negative-edge-aligned cycle and never raises both strobes together. It holds the slow-edge strobe for an exact number of cycles, so the expected count is computed as the number of strobes divided by the effective divisor. The coincident-increment case is the only place where a slow edge and a status read share a cycle, and that overlap is intended.

// File: rtl/rtt_pkg.sv
// Package: shared register map and bit positions for the slow tick timer.
// Assumes a word-addressed register file with a 2-bit address.
package rtt_pkg;
    localparam int ADDR_W   = 2;
    localparam int IEN_BIT  = 17;
    localparam int RST_BIT  = 18;
    localparam int FLAG_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MODE  = 2'd0,
        ADDR_STAT  = 2'd1,
        ADDR_COUNT = 2'd2
    } reg_addr_e;
endpackage

// File: rtl/rtt_prescaler.sv
// Module: divides slow-edge strobes by the effective divisor and emits a
// one-cycle tick on the edge that completes each division run.
// Assumes pre_val changes only in a cycle where restart is high.
module rtt_prescaler #(
    parameter int PRE_W   = 16,
    parameter int MIN_DIV = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_edge,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_val,
    output logic             tick
);
    localparam int DIV_W = PRE_W + 1;

    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] div_cnt;
    logic             at_last;

    // Map the raw divisor field onto the effective divisor.
    generate
        if (MIN_DIV > 1) begin : g_clamp
            always_comb begin
                if (pre_val == '0)
                    eff_div = DIV_W'(1) << PRE_W;
                else if (pre_val < PRE_W'(MIN_DIV))
                    eff_div = DIV_W'(MIN_DIV);
                else
                    eff_div = {1'b0, pre_val};
            end
        end else begin : g_noclamp
            always_comb begin
                if (pre_val == '0)
                    eff_div = DIV_W'(1) << PRE_W;
                else
                    eff_div = {1'b0, pre_val};
            end
        end
    endgenerate

    assign at_last = (div_cnt == eff_div - DIV_W'(1));
    assign tick    = slow_edge && !restart && at_last;

    // Advance the divider on each slow edge, wrap at the last position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (restart)
            div_cnt <= '0;
        else if (slow_edge)
            div_cnt <= at_last ? '0 : div_cnt + DIV_W'(1);
    end

    // R2: the divider position always stays below the effective divisor
    a_r2_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < eff_div);

    // R2: a tick only ever comes from a slow edge
    a_r2_tick_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> slow_edge);

    // R2: without a slow edge or a restart the divider holds
    a_r2_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_edge && !restart) |=> $stable(div_cnt));
endmodule

// File: rtl/rtt_counter.sv
// Module: the tick counter; advances on each tick and clears on restart.
// Assumes tick is already suppressed in a restart cycle.
module rtt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    // Count ticks, restart wins over any tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (tick)
            count <= count + CNT_W'(1);
    end

    // R4: a restart leaves the counter at zero
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));

    // R2: each tick adds exactly one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (count == $past(count) + CNT_W'(1)));

    // R2: no tick and no restart means no change
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));
endmodule

// File: rtl/rtt_regs.sv
// Module: mode and status registers, restart gating, pending flag, read mux
// and interrupt output. Assumes bus_wr and bus_rd are never high together.
module rtt_regs
    import rtt_pkg::*;
#(
    parameter int PRE_W     = 16,
    parameter int CNT_W     = 32,
    parameter int DATA_W    = 32,
    parameter int PRE_RESET = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output logic [PRE_W-1:0]  pre_val,
    output logic              restart,
    output logic              irq
);
    logic ien_q;
    logic flag_q;
    logic mode_wr;
    logic stat_rd;

    assign mode_wr = wr_en && (addr == ADDR_MODE);
    assign stat_rd = rd_en && (addr == ADDR_STAT);
    assign restart = mode_wr && wdata[RST_BIT] && !ien_q;
    assign irq     = flag_q && ien_q;

    // Store the enable on any mode write, the divisor only on an accepted restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q   <= 1'b0;
            pre_val <= PRE_W'(PRE_RESET);
        end else begin
            if (mode_wr)
                ien_q <= wdata[IEN_BIT];
            if (restart)
                pre_val <= wdata[PRE_W-1:0];
        end
    end

    // Pending flag: set by a tick, cleared by a status read, tick wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (tick)
            flag_q <= 1'b1;
        else if (stat_rd)
            flag_q <= 1'b0;
    end

    // Read data selected by the word address.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_MODE: begin
                rdata[PRE_W-1:0] = pre_val;
                rdata[IEN_BIT]   = ien_q;
            end
            ADDR_STAT:  rdata[FLAG_BIT]  = flag_q;
            ADDR_COUNT: rdata[CNT_W-1:0] = count;
            default:    rdata = '0;
        endcase
    end

    // R5: a restart attempt with the enable set keeps the divisor
    a_r5_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wdata[RST_BIT] && ien_q) |=> $stable(pre_val));

    // R8: a tick always leaves the flag set, even alongside a status read
    a_r8_tick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag_q);

    // R7: a status read without a tick clears the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tick) |=> !flag_q);

    // R6, R9: the flag holds until a status read
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !stat_rd) |=> flag_q);
endmodule

// File: rtl/slow_tick_timer.sv
// Module: top of the prescaled slow-clock tick timer. Joins the register
// block, the divider and the tick counter. Assumes one clock domain, with the
// slow clock presented as a one-cycle edge strobe.
module slow_tick_timer #(
    parameter int PRE_W     = 16,
    parameter int CNT_W     = 32,
    parameter int DATA_W    = 32,
    parameter int MIN_DIV   = 3,
    parameter int PRE_RESET = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_edge,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    logic [PRE_W-1:0] pre_val;
    logic             restart;
    logic             tick;
    logic [CNT_W-1:0] count;

    rtt_regs #(
        .PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .PRE_RESET(PRE_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .tick(tick), .count(count),
        .rdata(bus_rdata), .pre_val(pre_val), .restart(restart), .irq(irq)
    );

    rtt_prescaler #(
        .PRE_W(PRE_W), .MIN_DIV(MIN_DIV)
    ) u_presc (
        .clk(clk), .rst_n(rst_n), .slow_edge(slow_edge), .restart(restart),
        .pre_val(pre_val), .tick(tick)
    );

    rtt_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .count(count)
    );
endmodule

// File: tb/slow_tick_timer_bench.sv
// Bench: sweeps the divisor settings and checks counts, flag and interrupt.
module slow_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_edge = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    localparam logic [1:0] A_MODE = 2'd0, A_STAT = 2'd1, A_CNT = 2'd2;
    localparam logic [31:0] RST_B = 32'h0004_0000, IEN_B = 32'h0002_0000;

    slow_tick_timer u_slow_tick_timer (
        .clk(clk), .rst_n(rst_n), .slow_edge(slow_edge), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        if (n > 0) begin
            @(negedge clk) slow_edge = 1'b1;
            repeat (n) @(negedge clk);
            slow_edge = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int eff(input int p);
        if (p == 0) return 65536;
        if (p < 3) return 3;
        return p;
    endfunction

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int pv [14] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 17, 32};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_MODE, rv); check("R1 mode", rv, 32'h0000_8000);
        rd(A_STAT, rv); check("R1 status", rv, 32'h0);
        rd(A_CNT, rv);  check("R1 counter", rv, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 no strobe, no advance
        repeat (50) @(negedge clk);
        rd(A_CNT, rv); check("R2 idle counter", rv, 32'h0);

        // R2 R3 R4 sweep of small divisors
        foreach (pv[i]) begin
            int e;
            e = eff(pv[i]);
            wr(A_MODE, RST_B | pv[i]);
            rd(A_MODE, rv); check("R4 mode load", rv, 32'(pv[i]));
            rd(A_CNT, rv);  check("R4 counter cleared", rv, 32'h0);
            pulses(e - 1);
            rd(A_CNT, rv);  check("R3 before wrap", rv, 32'h0);
            pulses(1);
            rd(A_CNT, rv);  check("R2 first tick", rv, 32'h1);
            pulses(2 * e);
            rd(A_CNT, rv);  check("R2 three ticks", rv, 32'h3);
            rd(A_STAT, rv); check("R6 flag set", rv, 32'h2);
        end

        // R4 restart mid-division clears the divider
        wr(A_MODE, RST_B | 32'd6);
        pulses(4);
        wr(A_MODE, RST_B | 32'd6);
        pulses(5);
        rd(A_CNT, rv); check("R4 divider cleared", rv, 32'h0);
        pulses(1);
        rd(A_CNT, rv); check("R4 full run after restart", rv, 32'h1);

        // R3 divisor 0 acts as 65536
        wr(A_MODE, RST_B);
        pulses(65535);
        rd(A_CNT, rv); check("R3 zero before wrap", rv, 32'h0);
        pulses(1);
        rd(A_CNT, rv); check("R3 zero wraps at 65536", rv, 32'h1);

        // R5 refused restart while enabled
        wr(A_MODE, RST_B | 32'd5);
        rd(A_STAT, rv);
        wr(A_MODE, IEN_B | 32'd5);
        pulses(10);
        wr(A_MODE, RST_B | IEN_B | 32'd7);
        rd(A_MODE, rv); check("R5 divisor kept", rv, 32'h0002_0005);
        rd(A_CNT, rv);  check("R5 counter kept", rv, 32'h2);
        pulses(4);
        rd(A_CNT, rv);  check("R5 divider kept", rv, 32'h2);
        pulses(1);
        rd(A_CNT, rv);  check("R5 old period", rv, 32'h3);

        // R6 R9 level interrupt held across other reads
        check("R6 irq high", {31'b0, irq}, 32'h1);
        repeat (20) @(negedge clk);
        rd(A_MODE, rv); check("R9 restart bit reads 0", rv, 32'h0002_0005);
        rd(A_CNT, rv);
        check("R9 irq after other reads", {31'b0, irq}, 32'h1);

        // R7 status read acknowledges
        rd(A_STAT, rv); check("R7 status read value", rv, 32'h2);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);
        rd(A_STAT, rv); check("R7 flag cleared", rv, 32'h0);

        // R8 tick coinciding with status read
        pulses(4);
        @(negedge clk);
        slow_edge = 1'b1; bus_rd = 1'b1; bus_addr = A_STAT;
        #1 rv = bus_rdata;
        check("R8 status before tick", rv, 32'h0);
        @(negedge clk);
        slow_edge = 1'b0; bus_rd = 1'b0;
        check("R8 irq kept", {31'b0, irq}, 32'h1);
        rd(A_STAT, rv); check("R8 flag kept", rv, 32'h2);
        rd(A_CNT, rv);  check("R8 counter", rv, 32'h4);

        // R6 flag without enable gives no interrupt
        wr(A_MODE, 32'd5);
        pulses(5);
        check("R6 irq gated", {31'b0, irq}, 32'h0);
        rd(A_STAT, rv); check("R6 flag without enable", rv, 32'h2);
        rd(A_MODE, rv); check("R5 enable write alone", rv, 32'h5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule